// File: doc/BRIEF.md
# Supervisor Trap Vector Register with Target Generation

This block holds the 64-bit supervisor trap-vector register and works out where a trap should jump. Software reaches the register through a simple CSR port: an address, a write strobe, write data and combinational read data. The upper 62 bits hold a word-aligned base and the low two bits hold the vectoring mode.

Every software write is legalized before it is stored. A base that is not a sign-extended 39-bit virtual address is refused, and the stored base stays as it was. A mode value that the configuration does not support is also refused, and the stored mode stays as it was, so the register never holds an illegal encoding. The base and mode are judged separately, so one write can update one field and leave the other.

On the trap side, the block takes an interrupt flag and a cause code and returns the jump address at once. In direct mode, every trap goes to the base. In vectored mode, interrupts are spread over a table of word-sized slots that starts at the base, and exceptions still go to the base. Two parameters say which modes the register supports.

Top module: `trap_vector_csr`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads zero base with mode 0 (direct) when direct mode is supported, and the jump target is 0.
- R2: When csr_addr equals 0x105, csr_rdata returns the stored base in bits 63:2 and the mode in bits 1:0 in the same cycle. At any other address csr_rdata is 0.
- R3: A write (csr_we high, csr_addr 0x105) updates the register on the next rising clock edge. A write with csr_we low, or to any other address, changes nothing.
- R4: When bits 63:38 of the write data are not all equal, the stored base keeps its previous value. The mode field of that write is still judged on its own.
- R5: A written mode of 0 is stored when direct mode is supported. A written mode of 1 is stored when vectored mode is supported.
- R6: A written mode of 2, 3, or a supported-mode value that the configuration disables leaves the stored mode unchanged.
- R7: In mode 0, trap_target equals the base shifted left by two, for interrupts and exceptions alike.
- R8: In mode 1 with trap_is_irq high, trap_target equals the base shifted left by two plus four times trap_cause, modulo 2^64.
- R9: In mode 1 with trap_is_irq low, trap_target equals the base shifted left by two.
- R10: With only vectored mode supported, the mode resets to 1 and a written mode of 0 is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data, legalized before storage |
| csr_rdata | output | 64 | Read data, combinational |
| trap_is_irq | input | 1 | High for an asynchronous interrupt, low for an exception |
| trap_cause | input | 6 | Cause code without the interrupt flag |
| trap_target | output | 64 | Computed jump address |

## Verification
The bench writes a base with bit 38 set and the bits above it clear. A design that tests fewer upper bits would accept that base and move the target. It writes mode values 2 and 3 and checks that the old mode stays; a design that stored them, or forced a fixed value, would change the read data. It sets a large base and the largest cause so that the vectored sum wraps past 2^64, and it checks that exceptions in vectored mode are not offset. A vectored-only instance shows that the reset mode and the refusal of mode 0 follow the configuration and are not hard-wired.

// File: rtl/trap_vector_pkg.sv
package trap_vector_pkg;
   localparam int unsigned MODE_W = 2;
   localparam logic [MODE_W-1:0] MODE_DIRECT   = 2'd0;
   localparam logic [MODE_W-1:0] MODE_VECTORED = 2'd1;
   localparam int unsigned SLOT_SHIFT = 2;
endpackage

// File: rtl/tvec_decode.sv
module tvec_decode #(
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h105
) (
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_we,
   output logic              sel,
   output logic              wr_en
);
   assign sel   = (csr_addr == CSR_ADDR);
   assign wr_en = sel & csr_we;
endmodule

// File: rtl/tvec_legalize.sv
module tvec_legalize
   import trap_vector_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned VA_BITS = 39,
   parameter bit SUPPORT_DIRECT   = 1'b1,
   parameter bit SUPPORT_VECTORED = 1'b1
) (
   input  logic [XLEN-1:0]        wdata,
   input  logic [XLEN-3:0]        cur_base,
   input  logic [MODE_W-1:0]      cur_mode,
   output logic [XLEN-3:0]        nxt_base,
   output logic [MODE_W-1:0]      nxt_mode
);
   localparam int unsigned UPPER_W = XLEN - VA_BITS + 1;

   logic [UPPER_W-1:0] upper;
   logic               canon;
   logic [MODE_W-1:0]  wmode;
   logic               mode_ok;

   assign upper = wdata[XLEN-1:VA_BITS-1];
   assign canon = (&upper) | ~(|upper);
   assign wmode = wdata[MODE_W-1:0];

   always_comb begin
      mode_ok = 1'b0;
      if (SUPPORT_DIRECT && (wmode == MODE_DIRECT))
         mode_ok = 1'b1;
      if (SUPPORT_VECTORED && (wmode == MODE_VECTORED))
         mode_ok = 1'b1;
   end

   assign nxt_base = canon   ? wdata[XLEN-1:MODE_W] : cur_base;
   assign nxt_mode = mode_ok ? wmode                : cur_mode;
endmodule

// File: rtl/tvec_target.sv
module tvec_target
   import trap_vector_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned CAUSE_W = 6,
   parameter bit SUPPORT_VECTORED = 1'b1
) (
   input  logic [XLEN-3:0]    base,
   input  logic [MODE_W-1:0]  mode,
   input  logic               irq,
   input  logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    target
);
   logic [XLEN-1:0] base_addr;
   assign base_addr = {base, {SLOT_SHIFT{1'b0}}};

   generate
      if (SUPPORT_VECTORED) begin : g_vec
         logic [XLEN-1:0] slot_off;
         logic            spread;
         always_comb begin
            slot_off = '0;
            slot_off[CAUSE_W+SLOT_SHIFT-1:SLOT_SHIFT] = cause;
         end
         assign spread = irq && (mode == MODE_VECTORED);
         assign target = spread ? (base_addr + slot_off) : base_addr;
      end else begin : g_dir
         logic unused_tgt_inputs;
         assign unused_tgt_inputs = ^{mode, irq, cause};
         assign target = base_addr;
      end
   endgenerate
endmodule

// File: rtl/trap_vector_csr.sv
module trap_vector_csr
   import trap_vector_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned VA_BITS = 39,
   parameter int unsigned CAUSE_W = 6,
   parameter int unsigned ADDR_W  = 12,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h105,
   parameter bit SUPPORT_DIRECT   = 1'b1,
   parameter bit SUPPORT_VECTORED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  csr_addr,
   input  logic               csr_we,
   input  logic [XLEN-1:0]    csr_wdata,
   output logic [XLEN-1:0]    csr_rdata,
   input  logic               trap_is_irq,
   input  logic [CAUSE_W-1:0] trap_cause,
   output logic [XLEN-1:0]    trap_target
);
   localparam int unsigned BASE_W = XLEN - MODE_W;
   localparam logic [MODE_W-1:0] MODE_RST = SUPPORT_DIRECT ? MODE_DIRECT : MODE_VECTORED;

   generate
      if (!(SUPPORT_DIRECT || SUPPORT_VECTORED)) begin : g_chk_modes
         $error("trap_vector_csr: at least one vectoring mode must be supported");
      end
      if (VA_BITS < 2 || VA_BITS > XLEN) begin : g_chk_va
         $error("trap_vector_csr: VA_BITS out of range");
      end
      if (CAUSE_W + SLOT_SHIFT > XLEN) begin : g_chk_cause
         $error("trap_vector_csr: CAUSE_W too wide for XLEN");
      end
   endgenerate

   logic [BASE_W-1:0] base_q, base_d;
   logic [MODE_W-1:0] mode_q, mode_d;
   logic              sel, wr_en;

   tvec_decode #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_dec (
      .csr_addr (csr_addr),
      .csr_we   (csr_we),
      .sel      (sel),
      .wr_en    (wr_en)
   );

   tvec_legalize #(
      .XLEN(XLEN), .VA_BITS(VA_BITS),
      .SUPPORT_DIRECT(SUPPORT_DIRECT), .SUPPORT_VECTORED(SUPPORT_VECTORED)
   ) u_legal (
      .wdata    (csr_wdata),
      .cur_base (base_q),
      .cur_mode (mode_q),
      .nxt_base (base_d),
      .nxt_mode (mode_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mode_q <= MODE_RST;
      end else if (wr_en) begin
         base_q <= base_d;
         mode_q <= mode_d;
      end
   end

   assign csr_rdata = sel ? {base_q, mode_q} : '0;

   tvec_target #(
      .XLEN(XLEN), .CAUSE_W(CAUSE_W), .SUPPORT_VECTORED(SUPPORT_VECTORED)
   ) u_tgt (
      .base   (base_q),
      .mode   (mode_q),
      .irq    (trap_is_irq),
      .cause  (trap_cause),
      .target (trap_target)
   );
endmodule

// File: rtl/trap_vector_csr_chk.sv
module trap_vector_csr_chk
   import trap_vector_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned VA_BITS = 39,
   parameter int unsigned CAUSE_W = 6,
   parameter int unsigned ADDR_W  = 12,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h105,
   parameter bit SUPPORT_DIRECT   = 1'b1,
   parameter bit SUPPORT_VECTORED = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  csr_addr,
   input logic               csr_we,
   input logic [XLEN-1:0]    csr_wdata,
   input logic [XLEN-1:0]    csr_rdata,
   input logic               trap_is_irq,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [XLEN-1:0]    trap_target,
   input logic [XLEN-3:0]    base_q,
   input logic [MODE_W-1:0]  mode_q
);
   logic hit_wr, noncanon;
   logic [XLEN-1:0] cause_ext;
   assign hit_wr   = csr_we && (csr_addr == CSR_ADDR);
   assign noncanon = (csr_wdata[XLEN-1:VA_BITS-1] != '0) &&
                     (csr_wdata[XLEN-1:VA_BITS-1] != '1);
   assign cause_ext = XLEN'(trap_cause) << SLOT_SHIFT;

   p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == CSR_ADDR) |-> (csr_rdata == {base_q, mode_q}));

   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_wr |=> ($stable(base_q) && $stable(mode_q)));

   p_noncanon_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && noncanon) |=> $stable(base_q));

   p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((SUPPORT_DIRECT && mode_q == MODE_DIRECT) ||
       (SUPPORT_VECTORED && mode_q == MODE_VECTORED)));

   p_direct_tgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_DIRECT) |-> (trap_target == {base_q, 2'b00}));

   p_vec_irq_tgt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_VECTORED && trap_is_irq) |->
         (trap_target == ({base_q, 2'b00} + cause_ext)));

   p_exc_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_is_irq |-> (trap_target == {base_q, 2'b00}));
endmodule

bind trap_vector_csr trap_vector_csr_chk #(
   .XLEN(XLEN), .VA_BITS(VA_BITS), .CAUSE_W(CAUSE_W), .ADDR_W(ADDR_W),
   .CSR_ADDR(CSR_ADDR), .SUPPORT_DIRECT(SUPPORT_DIRECT),
   .SUPPORT_VECTORED(SUPPORT_VECTORED)
) u_chk (.*);

// File: tb/trap_vector_csr_test.sv
module trap_vector_csr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = 12'h105;
   logic        csr_we = 1'b0;
   logic        vo_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic        trap_is_irq = 1'b0;
   logic [5:0]  trap_cause = '0;
   logic [63:0] csr_rdata, trap_target, vo_rdata, vo_target;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   trap_vector_csr uut (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_is_irq(trap_is_irq),
      .trap_cause(trap_cause), .trap_target(trap_target)
   );

   trap_vector_csr #(.SUPPORT_DIRECT(1'b0)) uut_vo (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(vo_we),
      .csr_wdata(csr_wdata), .csr_rdata(vo_rdata), .trap_is_irq(trap_is_irq),
      .trap_cause(trap_cause), .trap_target(vo_target)
   );

   typedef struct packed {
      logic        we;
      logic [11:0] addr;
      logic [63:0] wdata;
      logic        irq;
      logic [5:0]  cause;
      logic [63:0] exp_rd;
      logic [63:0] exp_tgt;
      logic [7:0]  rq_rd;
      logic [7:0]  rq_tg;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      // R3 R5 write canonical base, mode 1; R8 irq cause 5
      '{1'b1, 12'h105, 64'h0000_0000_8000_1001, 1'b1, 6'd5,
        64'h0000_0000_8000_1001, 64'h0000_0000_8000_1014, 8'd3, 8'd8},
      // R9 exception in vectored mode
      '{1'b0, 12'h105, 64'h0, 1'b0, 6'd5,
        64'h0000_0000_8000_1001, 64'h0000_0000_8000_1000, 8'd3, 8'd9},
      // R3 write to another address ignored; R8 cause 3
      '{1'b1, 12'h106, 64'h1234, 1'b1, 6'd3,
        64'h0000_0000_8000_1001, 64'h0000_0000_8000_100C, 8'd3, 8'd8},
      // R4 bit 38 set alone: base kept, mode 0 taken; R7 direct
      '{1'b1, 12'h105, 64'h0000_0040_0000_0000, 1'b1, 6'd5,
        64'h0000_0000_8000_1000, 64'h0000_0000_8000_1000, 8'd4, 8'd7},
      // R6 mode 3 refused; R7 sign-extended canonical base
      '{1'b1, 12'h105, 64'hFFFF_FFC0_0000_0003, 1'b1, 6'd2,
        64'hFFFF_FFC0_0000_0000, 64'hFFFF_FFC0_0000_0000, 8'd6, 8'd7},
      // R5 mode 1; R8 sum wraps past 2^64
      '{1'b1, 12'h105, 64'hFFFF_FFFF_FFFF_FFF1, 1'b1, 6'd63,
        64'hFFFF_FFFF_FFFF_FFF1, 64'h0000_0000_0000_00EC, 8'd5, 8'd8},
      // R3 strobe low ignored; R9
      '{1'b0, 12'h105, 64'h0000_0000_0000_0000, 1'b0, 6'd63,
        64'hFFFF_FFFF_FFFF_FFF1, 64'hFFFF_FFFF_FFFF_FFF0, 8'd3, 8'd9},
      // R6 mode 2 refused, base 0 taken; R8
      '{1'b1, 12'h105, 64'h0000_0000_0000_0002, 1'b1, 6'd1,
        64'h0000_0000_0000_0001, 64'h0000_0000_0000_0004, 8'd6, 8'd8}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #(10 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1;
      // R1 during reset
      check("R1 rdata in reset", csr_rdata, 64'h0);
      check("R1 target in reset", trap_target, 64'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata after reset", csr_rdata, 64'h0);
      // R10 vectored-only instance resets to mode 1
      check("R10 vo reset mode", vo_rdata, 64'h1);
      csr_addr = 12'h104; #1;
      check("R2 other address reads 0", csr_rdata, 64'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         csr_we = VECS[i].we; csr_addr = VECS[i].addr; csr_wdata = VECS[i].wdata;
         @(negedge clk);
         csr_we = 1'b0; csr_addr = 12'h105;
         trap_is_irq = VECS[i].irq; trap_cause = VECS[i].cause;
         #1;
         check($sformatf("R%0d vec %0d rdata", VECS[i].rq_rd, i), csr_rdata, VECS[i].exp_rd);
         check($sformatf("R%0d vec %0d target", VECS[i].rq_tg, i), trap_target, VECS[i].exp_tgt);
      end

      // R10 mode 0 refused by vectored-only instance, base still taken
      @(negedge clk);
      vo_we = 1'b1; csr_addr = 12'h105; csr_wdata = 64'h1000;
      @(negedge clk);
      vo_we = 1'b0; trap_is_irq = 1'b1; trap_cause = 6'd3; #1;
      check("R10 vo mode kept", vo_rdata, 64'h1001);
      check("R8 vo vectored target", vo_target, 64'h100C);
      check("R3 main unaffected by vo write", csr_rdata, 64'h1);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0; #1;
      check("R1 rdata after reset pulse", csr_rdata, 64'h0);
      check("R1 target after reset pulse", trap_target, 64'h0);
      check("R10 vo mode after reset pulse", vo_rdata, 64'h1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule